// File: doc/BRIEF.md
# Three-Channel Colour Matrix Converter

This block converts a stream of three-component pixels, 10 bits per component, through a programmable 3x3 matrix. A typical use is turning RGB graphics into limited-range YCbCr ahead of a video encoder. Before the multiply, each incoming component has its own signed offset added. The nine signed fixed-point weights are then applied, and each output row is summed at full precision, rounded, and scaled down by a fixed fraction plus a programmable extra shift. A per-row signed offset is added last, and the result is saturated to the component range. When conversion is switched off, the pixel passes through untouched with the same delay. A valid flag travels alongside every pixel.

Configuration is written through a plain write port, one packed word per address, into a staging copy. The staging copy moves into the working copy only on a frame-start pulse. A frame in flight therefore never sees a half-updated matrix.

Top module: `csc_matrix3`

## Requirements
- R1: After reset, out_valid is low and all output components are 0. The working configuration is identity weights (1024 on the diagonal, 0 elsewhere), zero offsets, shift 0 and conversion off, so pixels pass through unchanged.
- R2: out_valid equals in_valid from three clock edges earlier. The output data belongs to the pixel presented in that cycle, including during back-to-back streams.
- R3: With control bit 0 (address 10) clear, each output component equals the matching input component, whatever the other settings are.
- R4: With conversion on, output row i is clip(((sum over j of w_ij*(x_j+pre_j)) + 2^(9+s)) >>> (10+s) + post_i). w_ij is a 13-bit two's-complement weight where 1024 means 1.0, and s is the extra shift.
- R5: The weights are written in row-major order, two per word. The first weight of a word is in bits 28:16 and the second in bits 12:0. Address 2 holds w00/w01, address 3 holds w02/w10, address 4 holds w11/w12 and address 5 holds w20/w21. Address 6 holds w22 alone in bits 28:16.
- R6: Offsets are 12-bit two's complement, with the first in bits 27:16 and the second in bits 11:0. Input offsets for channels 0 and 1 are at address 0, and channel 2 is at address 1, bits 11:0. Output offsets for rows 0 and 1 are at address 7, and row 2 is at address 8, bits 11:0.
- R7: Bits 18:16 of address 9 hold the extra right shift s (0 to 7) that is applied to the rounded sum.
- R8: Each converted component saturates: a negative result gives 0 and a result above 1023 gives 1023.
- R9: Writes only change the staging copy. The working copy, which the pixels use, loads from staging on a cycle where frame_start is high.
- R10: While out_valid is low, the output components keep the last pixel delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 29 | Configuration word |
| frame_start | input | 1 | Loads staged configuration into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | 10 | Input component 0 |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
The bench uses the default parameters: 10-bit components, 13-bit weights with a 10-bit fraction, 12-bit offsets and a 3-bit shift. At these widths the extremes of every field can be reached directly. The bench exercises the most negative input offset (-2048), weights near the ±4 limit, shifts that make half-LSB rounding visible, and offsets large enough to push results past both saturation rails. It also stages a new matrix while pixels are still flowing, to show that the old one stays in force until the frame-start pulse.

// File: rtl/csc_matrix3.sv
module csc_matrix3 #(
  parameter int PW   = 10,
  parameter int CW   = 13,
  parameter int OW   = 12,
  parameter int FRAC = 10,
  parameter int SW   = 3,
  parameter int AW   = 4
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [15+CW:0]  cfg_wdata,
  input  logic            frame_start,
  input  logic            in_valid,
  input  logic [PW-1:0]   in_c0,
  input  logic [PW-1:0]   in_c1,
  input  logic [PW-1:0]   in_c2,
  output logic            out_valid,
  output logic [PW-1:0]   out_c0,
  output logic [PW-1:0]   out_c1,
  output logic [PW-1:0]   out_c2
);
  localparam int AXW  = OW + 1;
  localparam int PRW  = AXW + CW;
  localparam int SUMW = PRW + 2;
  localparam int MAXV = (1 << PW) - 1;
  localparam logic signed [CW-1:0] ONE = CW'(1 << FRAC);

  logic signed [CW-1:0] st_coef [9];
  logic signed [CW-1:0] ac_coef [9];
  logic signed [OW-1:0] st_pre  [3];
  logic signed [OW-1:0] ac_pre  [3];
  logic signed [OW-1:0] st_post [3];
  logic signed [OW-1:0] ac_post [3];
  logic [SW-1:0] st_sh, ac_sh;
  logic          st_en, ac_en;

  logic [PW-1:0] pin [3];
  logic [PW-1:0] raw1 [3];
  logic [PW-1:0] raw2 [3];
  logic [PW-1:0] oq [3];
  logic signed [AXW-1:0]  a1 [3];
  logic signed [SUMW-1:0] s2 [3];
  logic v1, v2, en1, en2;

  assign pin[0] = in_c0;
  assign pin[1] = in_c1;
  assign pin[2] = in_c2;
  assign out_c0 = oq[0];
  assign out_c1 = oq[1];
  assign out_c2 = oq[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 9; k++) st_coef[k] <= (k % 4 == 0) ? ONE : '0;
      for (int k = 0; k < 3; k++) begin
        st_pre[k]  <= '0;
        st_post[k] <= '0;
      end
      st_sh <= '0;
      st_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0):  begin st_pre[0]  <= cfg_wdata[16 +: OW]; st_pre[1]  <= cfg_wdata[0 +: OW]; end
        AW'(1):  st_pre[2] <= cfg_wdata[0 +: OW];
        AW'(2):  begin st_coef[0] <= cfg_wdata[16 +: CW]; st_coef[1] <= cfg_wdata[0 +: CW]; end
        AW'(3):  begin st_coef[2] <= cfg_wdata[16 +: CW]; st_coef[3] <= cfg_wdata[0 +: CW]; end
        AW'(4):  begin st_coef[4] <= cfg_wdata[16 +: CW]; st_coef[5] <= cfg_wdata[0 +: CW]; end
        AW'(5):  begin st_coef[6] <= cfg_wdata[16 +: CW]; st_coef[7] <= cfg_wdata[0 +: CW]; end
        AW'(6):  st_coef[8] <= cfg_wdata[16 +: CW];
        AW'(7):  begin st_post[0] <= cfg_wdata[16 +: OW]; st_post[1] <= cfg_wdata[0 +: OW]; end
        AW'(8):  st_post[2] <= cfg_wdata[0 +: OW];
        AW'(9):  st_sh <= cfg_wdata[16 +: SW];
        AW'(10): st_en <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 9; k++) ac_coef[k] <= (k % 4 == 0) ? ONE : '0;
      for (int k = 0; k < 3; k++) begin
        ac_pre[k]  <= '0;
        ac_post[k] <= '0;
      end
      ac_sh <= '0;
      ac_en <= 1'b0;
    end else if (frame_start) begin
      ac_coef <= st_coef;
      ac_pre  <= st_pre;
      ac_post <= st_post;
      ac_sh   <= st_sh;
      ac_en   <= st_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    en1 <= ac_en;
    en2 <= en1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_ch
    logic signed [PRW-1:0]  p0, p1, p2;
    logic signed [SUMW:0]   half, rnd, shd;
    logic signed [SUMW+1:0] res;
    logic [PW-1:0]          clip;

    assign p0   = PRW'(a1[0]) * PRW'(ac_coef[3*g]);
    assign p1   = PRW'(a1[1]) * PRW'(ac_coef[3*g+1]);
    assign p2   = PRW'(a1[2]) * PRW'(ac_coef[3*g+2]);
    assign half = (SUMW+1)'(1) << (FRAC - 1 + int'(ac_sh));
    assign rnd  = (SUMW+1)'(s2[g]) + half;
    assign shd  = rnd >>> (FRAC + int'(ac_sh));
    assign res  = (SUMW+2)'(shd) + (SUMW+2)'(ac_post[g]);
    assign clip = res[SUMW+1] ? '0 : (|res[SUMW+1:PW]) ? PW'(MAXV) : res[PW-1:0];

    always_ff @(posedge clk) begin
      a1[g]   <= AXW'($signed({1'b0, pin[g]})) + AXW'(ac_pre[g]);
      raw1[g] <= pin[g];
      raw2[g] <= raw1[g];
      s2[g]   <= SUMW'(p0) + SUMW'(p1) + SUMW'(p2);
    end

    always_ff @(posedge clk) begin
      if (rst)     oq[g] <= '0;
      else if (v2) oq[g] <= en2 ? clip : raw2[g];
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid && !$past(ac_en, 3)) |->
      (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));

  a_r9_hold_working: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(ac_en) && $stable(ac_sh) && $stable(ac_coef[0]) &&
                      $stable(ac_pre[0]) && $stable(ac_post[0])));

  a_r10_keep_output: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !out_valid) |-> ($stable(out_c0) && $stable(out_c1) && $stable(out_c2)));
endmodule

// File: tb/test_csc_matrix3.sv
module test_csc_matrix3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [28:0] cfg_wdata = '0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic out_valid;
  logic [9:0] out_c0, out_c1, out_c2;

  csc_matrix3 i_csc_matrix3 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int s_coef[9], m_coef[9];
  int s_pre[3], m_pre[3], s_post[3], m_post[3];
  int s_sh = 0, m_sh = 0, s_en = 0, m_en = 0;

  logic [29:0] exp_q[$];
  int stamp_q[$];
  string tag_q[$];
  logic [29:0] last_exp = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int conv(int i, int x0, int x1, int x2);
    int a0, a1, a2, sum, r;
    a0 = x0 + m_pre[0];
    a1 = x1 + m_pre[1];
    a2 = x2 + m_pre[2];
    sum = m_coef[3*i]*a0 + m_coef[3*i+1]*a1 + m_coef[3*i+2]*a2;
    r = ((sum + (1 << (9 + m_sh))) >>> (10 + m_sh)) + m_post[i];
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  function automatic logic [28:0] pk2(int hi, int lo, bit co);
    logic [28:0] w;
    if (co) w = {hi[12:0], 3'b000, lo[12:0]};
    else    w = {1'b0, hi[11:0], 4'b0000, lo[11:0]};
    return w;
  endfunction

  task automatic wr(input int a, input logic [28:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coef(input int c[9]);
    s_coef = c;
    wr(2, pk2(c[0], c[1], 1));
    wr(3, pk2(c[2], c[3], 1));
    wr(4, pk2(c[4], c[5], 1));
    wr(5, pk2(c[6], c[7], 1));
    wr(6, pk2(c[8], 0, 1));
  endtask

  task automatic set_pre(input int a, input int b, input int c);
    s_pre[0] = a; s_pre[1] = b; s_pre[2] = c;
    wr(0, pk2(a, b, 0));
    wr(1, pk2(0, c, 0));
  endtask

  task automatic set_post(input int a, input int b, input int c);
    s_post[0] = a; s_post[1] = b; s_post[2] = c;
    wr(7, pk2(a, b, 0));
    wr(8, pk2(0, c, 0));
  endtask

  task automatic set_shift(input int s);
    logic [2:0] f;
    f = s[2:0];
    s_sh = s;
    wr(9, {10'b0, f, 16'b0});
  endtask

  task automatic set_en(input int e);
    s_en = e;
    wr(10, {28'b0, e[0]});
  endtask

  task automatic fs();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_coef = s_coef; m_pre = s_pre; m_post = s_post; m_sh = s_sh; m_en = s_en;
  endtask

  task automatic send(input int x0, input int x1, input int x2, input string tg);
    logic [29:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_c0 = x0[9:0]; in_c1 = x1[9:0]; in_c2 = x2[9:0];
    if (m_en != 0) begin
      e[29:20] = 10'(conv(0, x0, x1, x2));
      e[19:10] = 10'(conv(1, x0, x1, x2));
      e[9:0]   = 10'(conv(2, x0, x1, x2));
    end else e = {x0[9:0], x1[9:0], x2[9:0]};
    exp_q.push_back(e);
    stamp_q.push_back(cyc);
    tag_q.push_back(tg);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2", 32'(out_valid), 32'(0));
      else begin
        logic [29:0] e;
        int st;
        string tg;
        e = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        last_exp = e;
        check({out_c0, out_c1, out_c2} == e, tg, 32'({out_c0, out_c1, out_c2}), 32'(e));
        check(cyc == st + 3, "R2", 32'(cyc - st), 32'(3));
      end
    end
  end

  int ident[9] = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
  int ycc[9]   = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
  int gain[9]  = '{1536, 0, 0, 0, 2048, 0, 0, 0, 4095};
  int neg[9]   = '{-4096, 1024, 0, 0, 1024, -4096, 0, 0, 0};
  int wild[9]  = '{-4096, 4095, 7, 3, 3, 3, -1, -1, -1};

  initial begin
    s_coef = ident; m_coef = ident;
    for (int k = 0; k < 3; k++) begin s_pre[k] = 0; m_pre[k] = 0; s_post[k] = 0; m_post[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'(0));
    check({out_c0, out_c1, out_c2} == '0, "R1", 32'({out_c0, out_c1, out_c2}), 32'(0));
    // R1: default set-up passes pixels through
    send(5, 500, 1023, "R1");
    send(0, 1, 2, "R1");
    idle(6);
    // R4: identity with conversion on
    set_en(1);
    fs();
    send(100, 200, 300, "R4");
    send(1023, 0, 512, "R4");
    idle(6);
    // R9: staged matrix not yet in force
    set_coef(ycc);
    set_post(64, 512, 512);
    send(400, 300, 200, "R9");
    send(7, 8, 9, "R9");
    idle(6);
    fs();
    // R5: limited-range matrix active after frame start
    send(0, 0, 0, "R5");
    send(1023, 1023, 1023, "R5");
    send(1023, 0, 0, "R5");
    send(0, 0, 1023, "R5");
    send(512, 256, 128, "R5");
    idle(6);
    // R6: input offsets, with R8 saturation on both rails
    set_coef(ident);
    set_post(0, 0, 0);
    set_pre(-64, 100, -2048);
    fs();
    send(30, 1000, 700, "R8");
    send(500, 500, 500, "R6");
    send(1023, 200, 1023, "R6");
    idle(6);
    // R6/R8: output offsets pushing past both rails
    set_pre(0, 0, 0);
    set_post(-100, 2047, -2048);
    fs();
    send(50, 50, 50, "R8");
    send(1023, 0, 1023, "R8");
    idle(6);
    // R4 rounding with 1.5 weight, R7 shift
    set_post(0, 0, 0);
    set_coef(gain);
    fs();
    send(1, 1, 1, "R4");
    send(3, 5, 600, "R4");
    idle(6);
    set_shift(1);
    fs();
    send(1, 3, 1023, "R7");
    send(999, 2, 5, "R7");
    idle(6);
    set_shift(7);
    fs();
    send(1023, 1023, 1023, "R7");
    send(200, 600, 900, "R7");
    idle(6);
    set_shift(0);
    set_coef(neg);
    fs();
    send(300, 100, 50, "R8");
    send(10, 900, 20, "R4");
    idle(6);
    // R3: bypass ignores a wild matrix and offsets
    set_coef(wild);
    set_pre(-2048, 2047, 55);
    set_post(-2048, 2047, 300);
    set_shift(3);
    set_en(0);
    fs();
    send(7, 8, 9, "R3");
    send(1023, 0, 511, "R3");
    idle(6);
    // R2: back-to-back stream with conversion on
    set_en(1);
    set_pre(0, 0, 0);
    set_post(64, 512, 512);
    set_shift(0);
    set_coef(ycc);
    fs();
    for (int k = 0; k < 8; k++) send(k * 120, 1023 - k * 100, (k * 333) % 1024, "R2");
    idle(6);
    // R10: outputs hold the last pixel while idle
    check(out_valid == 1'b0, "R10", 32'(out_valid), 32'(0));
    check({out_c0, out_c1, out_c2} == last_exp, "R10", 32'({out_c0, out_c1, out_c2}), 32'(last_exp));
    idle(5);
    check({out_c0, out_c1, out_c2} == last_exp, "R10", 32'({out_c0, out_c1, out_c2}), 32'(last_exp));
    check(exp_q.size() == 0, "R2", 32'(exp_q.size()), 32'(0));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule